// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a single-master SPI engine running on the system clock. Each transfer moves one word in both directions. A one-cycle `start` strobe latches the mode inputs and the transmit word: clock polarity, clock phase, bit order, word width and target slave. The engine then drives an active-low select line to that slave and generates the serial clock at a fixed divide of the system clock. It drives `mosi` and samples `miso`. When the word is complete, it pulses `done` and presents the received word on `rx_word`.

Every word is framed by its own select assertion. The serial clock stays at its idle level for half a serial period after the select line falls and for half a period after the last sampling edge. Only then does the select line rise. Consecutive words to the same slave therefore always see the select line go high and fall again. This frame is what a clock-phase-0 slave needs to reload its first bit.

Top module: `spi_master`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ss_n` is all ones, `sclk` equals `cpol`, and `mosi`, `busy` and `done` are 0.
- R2: From the cycle after an accepted `start` until `done`, `ss_n` is all ones except for a single 0 at bit `slave_sel`. The index is the one latched at start, and the vector does not change during the word.
- R3: After `ss_n` falls, `sclk` holds its idle level for HALF = CLK_DIV/2 system clocks. After that it toggles once every HALF clocks, so one serial period lasts CLK_DIV clocks.
- R4: The word width W follows `width_sel`: 0 selects 8 bits, 1 selects 16 and 2 or 3 selects 32. Each word produces exactly 2·W `sclk` edges.
- R5: With `cpha`=0, the first data bit is on `mosi` when `ss_n` falls. Each bit is sampled on a leading (idle-to-active) edge, and `mosi` moves to the next bit on the trailing edges.
- R6: With `cpha`=1, `mosi` is 0 until the first leading edge. From that edge on, `mosi` changes on leading edges, and `miso` is sampled on trailing edges.
- R7: With `lsb_first`=0, bit W-1 of `tx_word` goes out first. With `lsb_first`=1, bit 0 goes out first. Received bits are placed by the same order into bits W-1..0 of `rx_word`, and the bits above W-1 read 0.
- R8: After the last edge, `sclk` stays idle for HALF clocks. Then `ss_n` returns to all ones in the same cycle that `done` is high, for exactly one cycle. That cycle comes (2·W+1)·HALF clocks after the `start` edge.
- R9: `busy` is high from the cycle after an accepted `start` until the `done` cycle. A `start` while `busy` is high has no effect: no change to the data, the slave, the timing or the number of words.
- R10: While idle, `sclk` follows the `cpol` input one clock later. Between two back-to-back words, `ss_n` is all ones for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one word; ignored while busy |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: least significant bit first |
| width_sel | input | 2 | Word width code (0: 8, 1: 16, 2/3: 32) |
| slave_sel | input | SEL_W | Index of the slave to select |
| tx_word | input | 32 | Word to transmit, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| ss_n | output | N_SLAVES | Active-low one-hot slave selects |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_word | output | 32 | Received word, right-aligned, held until next start |

## Verification
The embedded assertions watch several properties on every cycle. At most one select line is low at a time. No sample lands beyond the word width. The select lines are released when `done` is high. `done` never lasts two cycles. `busy` rises after an accepted start and falls only with `done`. Other behaviour can only be shown by the bench's directed scenarios, where a behavioural slave exchanges words with the engine. These cover the edge placement for each clock phase and polarity, the bit order, the half-period lead and tail, the exact latency, and the fact that a mid-transfer start leaves the word untouched.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int BITN_W  = IDX_W + 1;
    localparam int EDGE_W  = IDX_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_XFER  = 2'd2,
        ST_TRAIL = 2'd3
    } spi_state_e;

    // width code to number of bits
    function automatic logic [EDGE_W-1:0] width_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    width_bits = EDGE_W'(8);
            2'd1:    width_bits = EDGE_W'(16);
            default: width_bits = EDGE_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CNT_W'(HALF - 1));
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_select_decode.sv
module spi_select_decode #(
    parameter int N_SLAVES = 4,
    parameter int SEL_W    = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_d,
    input  logic [SEL_W-1:0]    idx_d,
    output logic [N_SLAVES-1:0] ss_n
);
    logic [N_SLAVES-1:0] ss_n_d, ss_n_q;

    always_comb begin
        ss_n_d = '1;
        for (int i = 0; i < N_SLAVES; i++) begin
            if (en_d && (idx_d == SEL_W'(i))) ss_n_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ss_n_q <= '1;
        else     ss_n_q <= ss_n_d;
    end

    assign ss_n = ss_n_q;

    // R2
    ss_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~ss_n_q) <= 1);

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_master_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] tx_word,
    input  logic [1:0]    wsel,
    input  logic          lsb_first,
    input  logic          advance,
    input  logic          sample,
    input  logic          miso,
    output logic          mosi_bit,
    output logic [DW-1:0] rx_word
);
    typedef struct packed {
        logic [DW-1:0]     tx;
        logic [DW-1:0]     rx;
        logic [BITN_W-1:0] bitn;
        logic              lsb;
        logic [1:0]        wsel;
    } eng_t;

    eng_t e_d, e_q;
    logic [EDGE_W-1:0] wbits, rev;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        wbits    = width_bits(e_q.wsel);
        rev      = wbits - EDGE_W'(1) - EDGE_W'(e_q.bitn);
        idx      = e_q.lsb ? e_q.bitn[IDX_W-1:0] : rev[IDX_W-1:0];
        mosi_bit = e_q.tx[idx];

        e_d = e_q;
        if (load) begin
            e_d.tx   = tx_word;
            e_d.rx   = '0;
            e_d.bitn = '0;
            e_d.lsb  = lsb_first;
            e_d.wsel = wsel;
        end else begin
            if (sample)  e_d.rx[idx] = miso;
            if (advance) e_d.bitn    = e_q.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    assign rx_word = e_q.rx;

    // R4
    sample_in_word_chk: assert property (@(posedge clk) disable iff (rst)
        sample |-> (EDGE_W'(e_q.bitn) < wbits));

endmodule

// File: rtl/spi_master.sv
module spi_master
    import spi_master_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int N_SLAVES = 4,
    parameter int SEL_W    = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                lsb_first,
    input  logic [1:0]          width_sel,
    input  logic [SEL_W-1:0]    slave_sel,
    input  logic [WORD_W-1:0]   tx_word,
    input  logic                miso,
    output logic                sclk,
    output logic [N_SLAVES-1:0] ss_n,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [WORD_W-1:0]   rx_word
);
    localparam int HALF = CLK_DIV / 2;

    typedef struct packed {
        spi_state_e        state;
        logic              sck;
        logic              ss_en;
        logic [SEL_W-1:0]  slave;
        logic              cpha;
        logic [1:0]        wsel;
        logic [EDGE_W-1:0] edge_n;
        logic              drv_en;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic tick, load, sample, advance, mosi_bit, leading;
    logic [EDGE_W-1:0] wbits, last_edge;

    spi_half_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (c_q.state != ST_IDLE),
        .tick (tick)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        load      = 1'b0;
        sample    = 1'b0;
        advance   = 1'b0;
        wbits     = width_bits(c_q.wsel);
        last_edge = {wbits[EDGE_W-2:0], 1'b0} - EDGE_W'(1);
        leading   = ~c_q.edge_n[0];

        case (c_q.state)
            ST_IDLE: begin
                c_d.sck = cpol;
                if (start) begin
                    c_d.state  = ST_LEAD;
                    c_d.ss_en  = 1'b1;
                    c_d.slave  = slave_sel;
                    c_d.cpha   = cpha;
                    c_d.wsel   = width_sel;
                    c_d.edge_n = '0;
                    c_d.drv_en = ~cpha;
                    load       = 1'b1;
                end
            end
            ST_LEAD, ST_XFER: begin
                if (tick) begin
                    c_d.sck = ~c_q.sck;
                    if (!c_q.cpha) begin
                        if (leading)                        sample  = 1'b1;
                        else if (c_q.edge_n != last_edge)   advance = 1'b1;
                    end else begin
                        if (leading) begin
                            c_d.drv_en = 1'b1;
                            if (c_q.edge_n != '0)           advance = 1'b1;
                        end else begin
                            sample = 1'b1;
                        end
                    end
                    c_d.edge_n = c_q.edge_n + 1'b1;
                    c_d.state  = (c_q.edge_n == last_edge) ? ST_TRAIL : ST_XFER;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    c_d.state  = ST_IDLE;
                    c_d.ss_en  = 1'b0;
                    c_d.drv_en = 1'b0;
                    c_d.done   = 1'b1;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q     <= '0;
            c_q.sck <= cpol;
        end else begin
            c_q <= c_d;
        end
    end

    spi_select_decode #(.N_SLAVES(N_SLAVES), .SEL_W(SEL_W)) u_select (
        .clk   (clk),
        .rst   (rst),
        .en_d  (c_d.ss_en),
        .idx_d (c_d.slave),
        .ss_n  (ss_n)
    );

    spi_bit_engine #(.DW(WORD_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .tx_word   (tx_word),
        .wsel      (width_sel),
        .lsb_first (lsb_first),
        .advance   (advance),
        .sample    (sample),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx_word   (rx_word)
    );

    assign sclk = c_q.sck;
    assign mosi = c_q.drv_en & mosi_bit;
    assign busy = (c_q.state != ST_IDLE);
    assign done = c_q.done;

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (&ss_n));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: tb/spi_master_bench.sv
module spi_master_bench;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [1:0]  slave_sel = 2'd0;
    logic [31:0] tx_word = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, busy, done;
    logic [3:0]  ss_n;
    logic [31:0] rx_word;

    int total = 0, failed = 0;

    // behavioural slave state
    logic        m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    int          m_w = 8;
    logic [1:0]  m_slave = 2'd0;
    logic [31:0] s_tx = '0, s_rx = '0;
    int          s_in_b = 0, s_out_b = 0;
    logic        ss_sel_n;

    always #10 clk = ~clk;

    spi_master u_spi_master (
        .clk(clk), .rst(rst), .start(start), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .width_sel(width_sel), .slave_sel(slave_sel),
        .tx_word(tx_word), .miso(miso), .sclk(sclk), .ss_n(ss_n),
        .mosi(mosi), .busy(busy), .done(done), .rx_word(rx_word)
    );

    assign ss_sel_n = ss_n[m_slave];

    function automatic int bidx(input int b);
        return m_lsb ? b : (m_w - 1 - b);
    endfunction

    always @(negedge ss_sel_n) begin
        s_rx = '0;
        s_in_b = 0;
        if (!m_cpha) begin
            miso = s_tx[bidx(0)];
            s_out_b = 1;
        end else begin
            s_out_b = 0;
        end
    end

    always @(sclk) begin
        if (ss_sel_n == 1'b0) begin
            if ((sclk != m_cpol) != m_cpha) begin
                // sampling edge
                if (s_in_b < m_w) s_rx[bidx(s_in_b)] = mosi;
                s_in_b++;
            end else begin
                if (s_out_b < m_w) miso = s_tx[bidx(s_out_b)];
                s_out_b++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ss_n == 4'hF, "R1", "ss_n in reset", ss_n, 4'hF);
        chk(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi in reset", {sclk, mosi}, 0);
        chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ss_n == 4'hF && !busy && !done, "R1", "state after reset",
            {ss_n, busy, done}, {4'hF, 2'b00});
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R10", "idle sclk follows cpol=1", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R10", "idle sclk follows cpol=0", sclk, 0);
    endtask

    task automatic run_word(input bit pol, input bit pha, input bit lsb,
                            input logic [1:0] ws, input logic [1:0] sl,
                            input logic [31:0] tx, input logic [31:0] stx,
                            input bit poke);
        int w, n, edges, bad_t, bad_ss;
        logic [31:0] mask, exp_ss;
        logic prev, first;
        string dtag;
        w = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        exp_ss = ~(32'd1 << sl);
        dtag = pha ? "R6/R7" : "R5/R7";
        @(negedge clk);
        cpol = pol; cpha = pha; lsb_first = lsb; width_sel = ws;
        slave_sel = sl; tx_word = tx;
        m_cpol = pol; m_cpha = pha; m_lsb = lsb; m_w = w; m_slave = sl; s_tx = stx;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        first = pha ? 1'b0 : (lsb ? tx[0] : tx[w-1]);
        chk(ss_n == exp_ss[3:0], "R2", "select at start", ss_n, exp_ss[3:0]);
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        chk(sclk == pol, "R3", "sclk idle at select", sclk, pol);
        chk(mosi == first, pha ? "R6" : "R5", "mosi before first edge", mosi, first);
        prev = sclk; edges = 0; bad_t = 0; bad_ss = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
                start = 1'b1; tx_word = ~tx; slave_sel = sl + 2'd1;
            end
            if (poke && n == 6) start = 1'b0;
            if (sclk != prev) begin
                edges++;
                if (n != H * edges) bad_t++;
                prev = sclk;
            end
            if (!done && ss_n != exp_ss[3:0]) bad_ss++;
        end
        chk(n == (2 * w + 1) * H, "R8", "latency start to done", n, (2 * w + 1) * H);
        chk(edges == 2 * w, "R4", "sclk edge count", edges, 2 * w);
        chk(bad_t == 0, "R3", "edge spacing (late/early edges)", bad_t, 0);
        chk(bad_ss == 0, "R2", "select stable during word", bad_ss, 0);
        chk(ss_n == 4'hF && !busy, "R8", "select released with done", {ss_n, busy}, {4'hF, 1'b0});
        chk(sclk == pol, "R8", "sclk idle at done", sclk, pol);
        chk(rx_word == (stx & mask), dtag, "received word", rx_word, stx & mask);
        chk(s_rx == (tx & mask), dtag, "slave received word", s_rx, tx & mask);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
        chk(ss_n == 4'hF, "R10", "select high between words", ss_n, 4'hF);
    endtask

    task automatic test_modes();
        run_word(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0000_00A5, 32'h0000_003C, 1'b0);
        run_word(1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 32'h0000_8123, 32'h0000_F00D, 1'b0);
        run_word(1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
        run_word(1'b1, 1'b1, 1'b1, 2'd0, 2'd3, 32'h0000_0001, 32'h0000_0080, 1'b0);
    endtask

    task automatic test_order_width();
        // R7: lsb-first and upper bits cleared
        run_word(1'b0, 1'b0, 1'b1, 2'd1, 2'd2, 32'hFFFF_0001, 32'hABCD_8002, 1'b0);
        // R4: code 3 acts as 32 bits
        run_word(1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 32'h8000_0001, 32'h0F0F_A5A5, 1'b0);
    endtask

    task automatic test_busy_ignore();
        run_word(1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 32'h0000_0096, 32'h0000_0069, 1'b1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && ss_n == 4'hF, "R9", "ignored start queued no word",
            {busy, ss_n}, {1'b0, 4'hF});
    endtask

    task automatic test_back_to_back();
        run_word(1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 32'h0000_0011, 32'h0000_00EE, 1'b0);
        run_word(1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 32'h0000_0022, 32'h0000_00DD, 1'b0);
    endtask

    initial begin
        test_reset();
        test_modes();
        test_order_width();
        test_busy_ignore();
        test_back_to_back();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule